// File: doc/BRIEF.md
# Priority-Arbitrated Local Store

A single-ported on-chip memory built from 128-bit lines that four requesters share under a fixed priority. Two of the requesters are block movers. A block mover transfers 128 bytes per grant as eight back-to-back line beats. The other two are narrow ports that move one 16-byte line per grant. Every requester uses the same request, grant and done handshake. Read data comes back on a shared bus, marked by a per-port valid strobe.

A narrow write can cover only part of a line, either because some byte enables are clear or because its byte address does not start at a line boundary. Such a write is finished inside the block: the line is read, the enabled bytes are merged in, and the line is written back in the next cycle. The requester sees only one extra cycle before done. While this read-modify-write runs, the arbiter grants nobody else.

Top module: `ls_local_store`

## Requirements
- R1: After reset, and until the first request, all bits of gnt_o, done_o and rvalid_o are 0.
- R2: Requests are sampled only while the store is idle, and the lowest-numbered pending port wins. Port 0 (register access) beats port 1 (block mover), which beats port 2 (data access), which beats port 3 (fetch block mover).
- R3: A block port (ports 1 and 3) is served in eight beats on eight consecutive cycles, with gnt_o high in each. Beat k touches line 8*addr[15:7]+k. No request that arrives after the first beat can interrupt the transfer.
- R4: A narrow write whose effective enables are all ones takes one cycle. In that cycle gnt_o and done_o are both high, and the whole line is replaced.
- R5: Any other narrow write takes two cycles: a grant cycle, then a done cycle with gnt_o low. Only the effectively enabled bytes of the line change.
- R6: The effective enable of a narrow write is be_i with bit k forced to 0 for every k below addr[3:0]. Enable bit k controls line bits 8k+7:8k, which take wdata bits 8k+7:8k.
- R7: The cycle after each read beat of port p, rvalid_o[p] is high and rdata_o holds that line. Block reads return lines in ascending order. A narrow read returns the whole line whatever addr[3:0] is.
- R8: During the second cycle of a read-modify-write, no port is granted. Arbitration resumes only after done.
- R9: Block ports ignore be_i and addr[6:0]: every beat writes or reads a full line.
- R10: At most one bit of gnt_o is high in any cycle. done_o[p] is high only in a cycle with gnt_o[p], or in the cycle right after a read-modify-write grant to p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 4 | Request per port, held until done |
| we_i | input | 4 | Write (1) or read (0) per port |
| addr_i | input | 4x16 | Byte address per port |
| wdata_i | input | 4x128 | Write line per port, current beat |
| be_i | input | 4x16 | Byte enables per port (narrow ports) |
| gnt_o | output | 4 | Beat taken at the next clock edge |
| done_o | output | 4 | Last cycle of the transfer |
| rvalid_o | output | 4 | Read data valid for that port |
| rdata_o | output | 128 | Shared read line |

## Verification
Two situations are provoked on purpose. In the first, a higher-priority request arrives while a block transfer or a read-modify-write is already running, so that arbitration and a busy sequence meet in the same cycle. In the second, several ports raise requests in the same cycle while the store is idle. Concurrent driver tasks issue the colliding requests, and the bench logs the order in which the ports are first granted. It also counts the grant cycles of each transfer and checks that they are contiguous, or that the done cycle is quiet. A shadow memory updated from the requirements feeds a queue of expected read lines.

// File: rtl/ls_pkg.sv
package ls_pkg;
    localparam int LINE_BYTES = 16;
    localparam int OFF_W      = $clog2(LINE_BYTES);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BEAT  = 2'd1,
        ST_MERGE = 2'd2
    } ls_state_e;

    // byte lanes below the start offset are never written
    function automatic logic [LINE_BYTES-1:0] eff_enables(
        input logic [LINE_BYTES-1:0] be,
        input logic [OFF_W-1:0]      off
    );
        logic [LINE_BYTES-1:0] keep;
        keep = {LINE_BYTES{1'b1}} << off;
        return be & keep;
    endfunction
endpackage

// File: rtl/ls_fixed_prio_arb.sv
module ls_fixed_prio_arb #(
    parameter int N  = 4,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  req_i,
    output logic [N-1:0]  win_o,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    logic [N:0] blocked;
    assign blocked[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_lvl
            assign win_o[i]       = req_i[i] & ~blocked[i];
            assign blocked[i + 1] = blocked[i] | req_i[i];
        end
    endgenerate

    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (win_o[i]) idx_o = IW'(i);
        end
    end

    assign any_o = blocked[N];
endmodule

// File: rtl/ls_byte_merge.sv
module ls_byte_merge #(
    parameter int BYTES = 16,
    localparam int W    = 8 * BYTES
) (
    input  logic [W-1:0]     old_i,
    input  logic [W-1:0]     new_i,
    input  logic [BYTES-1:0] en_i,
    output logic [W-1:0]     merged_o
);
    generate
        for (genvar b = 0; b < BYTES; b++) begin : g_lane
            assign merged_o[8*b +: 8] = en_i[b] ? new_i[8*b +: 8] : old_i[8*b +: 8];
        end
    endgenerate
endmodule

// File: rtl/ls_line_ram.sv
module ls_line_ram #(
    parameter int LINES = 4096,
    parameter int DW    = 128,
    localparam int LW   = $clog2(LINES)
) (
    input  logic          clk_i,
    input  logic          en_i,
    input  logic          we_i,
    input  logic [LW-1:0] line_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] mem [LINES];
    logic [DW-1:0] rdata_q;

    always_ff @(posedge clk_i) begin
        if (en_i && we_i) begin
            mem[line_i] <= wdata_i;
        end else if (en_i) begin
            rdata_q <= mem[line_i];
        end
    end

    assign rdata_o = rdata_q;
endmodule

// File: rtl/ls_local_store.sv
module ls_local_store
    import ls_pkg::*;
#(
    parameter int              NREQ        = 4,
    parameter int              LINES       = 4096,
    parameter int              BEATS       = 8,
    parameter logic [NREQ-1:0] BLOCK_PORTS = 4'b1010,
    localparam int             DW          = 8 * LINE_BYTES,
    localparam int             LW          = $clog2(LINES),
    localparam int             AW          = LW + OFF_W,
    localparam int             IW          = $clog2(NREQ),
    localparam int             BW          = $clog2(BEATS)
) (
    input  logic                             clk_i,
    input  logic                             rst_ni,
    input  logic [NREQ-1:0]                  req_i,
    input  logic [NREQ-1:0]                  we_i,
    input  logic [NREQ-1:0][AW-1:0]          addr_i,
    input  logic [NREQ-1:0][DW-1:0]          wdata_i,
    input  logic [NREQ-1:0][LINE_BYTES-1:0]  be_i,
    output logic [NREQ-1:0]                  gnt_o,
    output logic [NREQ-1:0]                  done_o,
    output logic [NREQ-1:0]                  rvalid_o,
    output logic [DW-1:0]                    rdata_o
);
    typedef struct packed {
        ls_state_e             st;
        logic [IW-1:0]         own;
        logic [BW-1:0]         beat;
        logic [LW-1:0]         line;
        logic                  we;
        logic                  rmw;
        logic [LINE_BYTES-1:0] mask;
        logic [DW-1:0]         hold;
        logic [NREQ-1:0]       rvalid;
    } seq_t;

    seq_t q, d;

    logic [NREQ-1:0] win;
    logic [IW-1:0]   win_idx;
    logic            any_req;
    logic            mem_en, mem_we;
    logic [LW-1:0]   mem_line;
    logic [DW-1:0]   mem_wdata, mem_rdata, merged;
    logic            cur_block;
    logic [LW-1:0]   cur_line;
    logic [LINE_BYTES-1:0] new_mask;

    ls_fixed_prio_arb #(.N(NREQ), .IW(IW)) u_arb (
        .req_i (req_i),
        .win_o (win),
        .idx_o (win_idx),
        .any_o (any_req)
    );

    ls_byte_merge #(.BYTES(LINE_BYTES)) u_merge (
        .old_i    (mem_rdata),
        .new_i    (q.hold),
        .en_i     (q.mask),
        .merged_o (merged)
    );

    ls_line_ram #(.LINES(LINES), .DW(DW)) u_ram (
        .clk_i   (clk_i),
        .en_i    (mem_en),
        .we_i    (mem_we),
        .line_i  (mem_line),
        .wdata_i (mem_wdata),
        .rdata_o (mem_rdata)
    );

    always_comb begin
        d         = q;
        d.rvalid  = '0;
        gnt_o     = '0;
        done_o    = '0;
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        cur_block = BLOCK_PORTS[q.own];
        cur_line  = cur_block ? {q.line[LW-1:BW], q.beat} : q.line;
        mem_line  = cur_line;
        mem_wdata = wdata_i[q.own];
        new_mask  = eff_enables(be_i[win_idx], addr_i[win_idx][OFF_W-1:0]);

        case (q.st)
            ST_IDLE: begin
                if (any_req) begin
                    d.st   = ST_BEAT;
                    d.own  = win_idx;
                    d.beat = '0;
                    d.we   = we_i[win_idx];
                    d.line = addr_i[win_idx][AW-1:OFF_W];
                    d.mask = new_mask;
                    d.rmw  = !BLOCK_PORTS[win_idx] && we_i[win_idx] &&
                             (new_mask != {LINE_BYTES{1'b1}});
                end
            end
            ST_BEAT: begin
                gnt_o[q.own]    = 1'b1;
                mem_en          = 1'b1;
                mem_we          = q.we && !q.rmw;
                d.rvalid[q.own] = !q.we;
                if (q.rmw) begin
                    d.hold = wdata_i[q.own];
                    d.st   = ST_MERGE;
                end else if (!cur_block || q.beat == BW'(BEATS - 1)) begin
                    done_o[q.own] = 1'b1;
                    d.st          = ST_IDLE;
                end else begin
                    d.beat = q.beat + 1'b1;
                end
            end
            ST_MERGE: begin
                mem_en        = 1'b1;
                mem_we        = 1'b1;
                mem_line      = q.line;
                mem_wdata     = merged;
                done_o[q.own] = 1'b1;
                d.st          = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            q <= '{st: ST_IDLE, own: '0, beat: '0, line: '0, we: 1'b0,
                   rmw: 1'b0, mask: '0, hold: '0, rvalid: '0};
        end else begin
            q <= d;
        end
    end

    assign rvalid_o = q.rvalid;
    assign rdata_o  = mem_rdata;

    a_r10_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(gnt_o));

    generate
        for (genvar i = 0; i < NREQ; i++) begin : g_chk
            a_r7_rvalid_after_beat: assert property (@(posedge clk_i) disable iff (!rst_ni)
                rvalid_o[i] |-> $past(gnt_o[i]));
            a_r10_done_framed: assert property (@(posedge clk_i) disable iff (!rst_ni)
                done_o[i] |-> (gnt_o[i] || $past(gnt_o[i])));
            if (BLOCK_PORTS[i]) begin : g_blk
                a_r3_beats_contiguous: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (gnt_o[i] && !done_o[i]) |=> gnt_o[i]);
            end else begin : g_nar
                a_r5_rmw_quiet_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (gnt_o[i] && !done_o[i]) |=> (done_o[i] && gnt_o == '0));
            end
            for (genvar j = 0; j < i; j++) begin : g_pri
                a_r2_higher_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
                    (q.st == ST_IDLE && req_i[j]) |=> !gnt_o[i]);
            end
        end
    endgenerate
endmodule

// File: tb/sim_ls_local_store.sv
`timescale 1ns/1ps
module sim_ls_local_store;
    localparam int NREQ  = 4;
    localparam int LINES = 4096;
    localparam int LW    = $clog2(LINES);
    localparam int AW    = LW + 4;
    localparam int DW    = 128;
    localparam logic [3:0] BLK = 4'b1010;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NREQ-1:0]         req = '0, we = '0;
    logic [NREQ-1:0][AW-1:0] addr = '0;
    logic [NREQ-1:0][DW-1:0] wd = '0;
    logic [NREQ-1:0][15:0]   be = '0;
    logic [NREQ-1:0]         gnt, done, rvalid;
    logic [DW-1:0]           rdata;

    int nchk = 0, nerr = 0;
    logic [DW-1:0] model [LINES];
    logic [DW-1:0] exp_q [$];
    int            exp_p [$];
    int            order_q [$];
    int            multi_gnt = 0;

    always #2.5 clk = ~clk;

    ls_local_store u0 (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
        .wdata_i(wd), .be_i(be), .gnt_o(gnt), .done_o(done),
        .rvalid_o(rvalid), .rdata_o(rdata)
    );

    task automatic chk(input string r, input bit ok, input logic [DW-1:0] act, input logic [DW-1:0] expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", r, act, expv);
        end
    endtask

    function automatic logic [DW-1:0] pat(input int seed, input int k);
        logic [31:0] w;
        w = 32'(seed * 131 + k * 7919) ^ 32'h5a5a_0000;
        return {w, ~w, w + 32'd3, 32'(k)};
    endfunction

    function automatic logic [DW-1:0] mrg(input logic [DW-1:0] o, input logic [DW-1:0] n, input logic [15:0] m);
        logic [DW-1:0] r;
        r = o;
        for (int b = 0; b < 16; b++) if (m[b]) r[8*b +: 8] = n[8*b +: 8];
        return r;
    endfunction

    // scoreboard monitor (R7)
    always @(negedge clk) begin
        if (rst_n) begin
            if (!$onehot0(gnt)) multi_gnt++;
            if (rvalid != '0) begin
                if (exp_q.size() == 0) begin
                    chk("R7 unexpected rvalid", 1'b0, DW'(rvalid), '0);
                end else begin
                    automatic logic [DW-1:0] e = exp_q.pop_front();
                    automatic int p = exp_p.pop_front();
                    chk("R7 rvalid port", rvalid == 4'(1 << p), DW'(rvalid), DW'(1 << p));
                    chk("R7 read line", rdata === e, rdata, e);
                end
            end
        end
    end

    task automatic run(input int p, input bit w, input logic [AW-1:0] a, input int seed,
                       input logic [15:0] bmask, input string tag);
        int nb, ng, cyc, first, dcyc;
        bit rmw, quiet;
        logic [15:0] em;
        logic [LW-1:0] ln;
        nb = BLK[p] ? 8 : 1;
        em = bmask & (16'hffff << a[3:0]);
        rmw = !BLK[p] && w && (em != 16'hffff);
        ng = 0; cyc = 0; first = -1; dcyc = -1; quiet = 1'b0;
        @(negedge clk);
        req[p] = 1'b1; we[p] = w; addr[p] = a; be[p] = bmask; wd[p] = pat(seed, 0);
        while (dcyc < 0 && cyc < 200) begin
            @(negedge clk);
            cyc++;
            if (gnt[p]) begin
                ln = BLK[p] ? {a[AW-1:7], 3'(ng)} : a[AW-1:4];
                if (first < 0) begin first = cyc; order_q.push_back(p); end
                wd[p] = pat(seed, ng);
                if (w) model[ln] = mrg(model[ln], pat(seed, ng), BLK[p] ? 16'hffff : em);
                else begin exp_q.push_back(model[ln]); exp_p.push_back(p); end
                ng++;
            end
            if (done[p]) begin dcyc = cyc; quiet = (gnt == '0); end
        end
        req[p] = 1'b0;
        if (rmw) begin
            chk({tag, " R5 two-cycle rmw"}, ng == 1 && dcyc == first + 1, DW'(dcyc - first), DW'(1));
            chk({tag, " R8 no grant in merge"}, quiet, DW'(quiet), DW'(1));
        end else begin
            chk({tag, " grant count"}, ng == nb, DW'(ng), DW'(nb));
            chk({tag, " done on last beat"}, dcyc == first + nb - 1, DW'(dcyc - first + 1), DW'(nb));
        end
    endtask

    task automatic chk_order(input string tag, input int e0, input int e1, input int e2, input int e3, input int n);
        int ev [4];
        bit ok;
        ev = '{e0, e1, e2, e3};
        ok = (order_q.size() == n);
        for (int i = 0; i < n && ok; i++) ok = (order_q[i] == ev[i]);
        chk(tag, ok, DW'(order_q.size() > 0 ? order_q[0] : -1), DW'(e0));
        order_q.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired (R3 or R8 hang)");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1: quiet outputs under and right after reset
        chk("R1 reset outputs", {gnt, done, rvalid} == '0, DW'({gnt, done, rvalid}), '0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle outputs", {gnt, done, rvalid} == '0, DW'({gnt, done, rvalid}), '0);

        // R3 R9: block write with junk offset and enables, then block read
        run(1, 1'b1, 16'h0435, 10, 16'h0001, "R3 R9 blk wr");
        run(1, 1'b0, 16'h0400, 0, 16'h0000, "R3 R7 blk rd");
        // R4: aligned full narrow write, read back
        run(2, 1'b1, 16'h2000, 20, 16'hffff, "R4 full wr");
        run(2, 1'b0, 16'h2000, 0, 16'h0000, "R4 rd");
        // R5: partial enables on a line written by the block mover
        run(0, 1'b1, 16'h0400, 30, 16'h00f0, "R5 partial");
        run(0, 1'b0, 16'h0409, 0, 16'h0000, "R5 R7 rd off");
        // R6: start offset clears low lanes
        run(2, 1'b1, 16'h0413, 40, 16'hffff, "R6 offset");
        run(2, 1'b0, 16'h0410, 0, 16'h0000, "R6 rd");
        // R7: fetch block read sees merged lines in order
        run(3, 1'b0, 16'h0400, 0, 16'h0000, "R7 fetch rd");
        order_q.delete();

        // R2: four requests in the same idle cycle
        fork
            run(3, 1'b0, 16'h0400, 0, 16'h0000, "R2 p3");
            run(2, 1'b0, 16'h2000, 0, 16'h0000, "R2 p2");
            run(1, 1'b0, 16'h0400, 0, 16'h0000, "R2 p1");
            run(0, 1'b0, 16'h0410, 0, 16'h0000, "R2 p0");
        join
        chk_order("R2 priority order", 0, 1, 2, 3, 4);

        // R3: top-priority request lands mid-block
        fork
            run(3, 1'b0, 16'h0400, 0, 16'h0000, "R3 p3 busy");
            begin repeat (3) @(negedge clk); run(0, 1'b0, 16'h2000, 0, 16'h0000, "R3 p0 late"); end
        join
        chk_order("R3 no preemption", 3, 0, 0, 0, 2);

        // R8: block request arrives during a read-modify-write
        fork
            run(2, 1'b1, 16'h2005, 50, 16'hffff, "R8 rmw");
            begin @(negedge clk); run(1, 1'b0, 16'h0400, 0, 16'h0000, "R8 p1"); end
        join
        chk_order("R8 rmw completes first", 2, 1, 0, 0, 2);
        run(2, 1'b0, 16'h2000, 0, 16'h0000, "R8 rd");

        repeat (3) @(negedge clk);
        chk("R7 all reads returned", exp_q.size() == 0, DW'(exp_q.size()), '0);
        chk("R10 one grant per cycle", multi_gnt == 0, DW'(multi_gnt), '0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule